// File: doc/BRIEF.md
# Time-Multiplexed Word Compute Tile Core

This block is the compute core of one tile in a mesh of small processors. A single 32-bit ALU is shared in time over a fixed schedule of instructions held in a small program store. The schedule runs from slot 0 to a programmable last slot and then starts again. One full pass is one cycle of the user circuit being emulated. Each slot reads two operands and writes one result. The operands can come from a result-node memory, an extra-node memory, one receive buffer per neighbour direction, or a large user data memory. The result can go to any of these stores or out towards the router.

The order of slots inside a pass decides what a stored value means. A value that is written before it is read in the same pass acts as a combinational wire. A value that is read before it is rewritten acts as a user register, because its readers see the value from the previous pass. Any instruction can be made conditional on one bit of a predicate register. That register stands in for a separate bit-level logic array and is loaded from outside. A skipped instruction writes nothing, but the schedule still moves on.

The program is loaded through a simple write port. The neighbour receive buffers are filled through one external write port per direction. When `run` is low, the schedule is frozen and no instruction has any effect.

Top module: `tile_seq_core`

## Requirements
- R1: After reset, `slot` is 0 and `user_tick`, `tx_valid` and `cmp_flag` are all 0.
- R2: On each clock with `run` high, `slot` advances by one, or wraps to 0 after executing slot `sched_last`. `user_tick` is high for exactly the one cycle that follows the execution of slot `sched_last`. With `run` low, `slot` holds and no instruction writes anything or emits anything.
- R3: The 49-bit instruction word has the following fields. Bits [48:46] hold the opcode. Bits [45:43] hold the source-A space and bits [42:32] its address. Bits [31:29] hold the source-B space and bits [28:18] its address. Bits [17:15] hold the destination space and bits [14:4] its address. Bit [3] enables the predicate, and bits [2:0] select the predicate bit. The space codes are: 0 result node, 1 extra node, 2 north, 3 south, 4 east, 5 west, 6 user memory. Code 7 reads as zero when used as a source and means the router output when used as a destination.
- R4: The opcodes are: 0 add, 1 subtract (A−B), 2 AND, 3 OR, 4 XOR, 5 pass A, 6 compare-equal, 7 pass B. All arithmetic is modulo 2^32.
- R5: Compare-equal produces 1 when A equals B and 0 otherwise. It also loads that bit into `cmp_flag`. No other opcode changes `cmp_flag`.
- R6: An instruction whose predicate enable is set is skipped when the selected predicate bit is 0. A skipped instruction makes no memory write, no router output and no flag update, and `slot` still advances.
- R7: A value written in one slot is seen by a later slot of the same pass (wire behaviour).
- R8: A value read in one slot and overwritten by a later slot of the same pass gives the reader the previous pass's value (register behaviour).
- R9: An executed instruction that targets the router raises `tx_valid` with the result on `tx_data` in the cycle after its slot. `tx_valid` is low after every other slot.
- R10: Each neighbour receive buffer holds 4 words and is written from outside through its bit of `nbr_we`, where bit 0 is north, 1 south, 2 east and 3 west. For direction d, the address is `nbr_addr[2d+1:2d]` and the data is `nbr_data[32d+31:32d]`. Instructions can read these words.
- R11: The user data memory holds 2048 words, and its highest address is distinct from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Schedule enable, one slot per clock |
| sched_last | input | 4 | Index of the last slot in a pass |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 4 | Program store write address |
| prog_data | input | 49 | Instruction word to store |
| pred_we | input | 1 | Predicate register load enable |
| pred_data | input | 8 | New predicate bits |
| nbr_we | input | 4 | Receive buffer write enables (N, S, E, W) |
| nbr_addr | input | 8 | Receive buffer addresses, 2 bits per direction |
| nbr_data | input | 128 | Receive buffer data, 32 bits per direction |
| slot | output | 4 | Slot that executes on the next enabled clock |
| user_tick | output | 1 | Pulse after a complete pass |
| tx_valid | output | 1 | Router output valid |
| tx_data | output | 32 | Router output word |
| cmp_flag | output | 1 | Result of the last executed compare |

## Verification
Memory writes land on the clock edge that ends a slot, so a later slot sees them with no extra delay. `tx_valid`, `tx_data`, `cmp_flag`, `user_tick` and `slot` are all registered and show the effect of a slot one clock after it starts. The bench therefore drives one slot per edge and samples 1 ns after that edge. Each router word is checked right after the edge that executed its slot, before the next slot can overwrite it. Because the wire and register cases depend only on slot order, they are checked over two consecutive passes, with the neighbour input changed between the passes.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int OPW  = 3;
  localparam int SELW = 3;

  typedef enum logic [OPW-1:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_XOR   = 3'd4,
    OP_PASSA = 3'd5,
    OP_CMPEQ = 3'd6,
    OP_PASSB = 3'd7
  } alu_op_e;

  typedef enum logic [SELW-1:0] {
    SP_RNODE = 3'd0,
    SP_XNODE = 3'd1,
    SP_NORTH = 3'd2,
    SP_SOUTH = 3'd3,
    SP_EAST  = 3'd4,
    SP_WEST  = 3'd5,
    SP_USER  = 3'd6,
    SP_PORT  = 3'd7
  } space_e;
endpackage

// File: rtl/tsc_alu.sv
module tsc_alu
  import tsc_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          eq
);
  always_comb begin
    eq = (a == b);
    unique case (op)
      OP_ADD:   y = a + b;
      OP_SUB:   y = a - b;
      OP_AND:   y = a & b;
      OP_OR:    y = a | b;
      OP_XOR:   y = a ^ b;
      OP_PASSA: y = a;
      OP_CMPEQ: y = {{(DW-1){1'b0}}, eq};
      default:  y = b;
    endcase
  end
endmodule

// File: rtl/tsc_seq.sv
module tsc_seq #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [SW-1:0] last,
  output logic [SW-1:0] slot,
  output logic          tick
);
  logic [SW-1:0] slot_d;
  logic          tick_d;

  always_comb begin
    slot_d = slot;
    tick_d = 1'b0;
    if (run) begin
      if (slot == last) begin
        slot_d = '0;
        tick_d = 1'b1;
      end else begin
        slot_d = slot + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
      tick <= 1'b0;
    end else begin
      slot <= slot_d;
      tick <= tick_d;
    end
  end
endmodule

// File: rtl/tsc_prog.sv
module tsc_prog #(
  parameter int IW    = 49,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [LW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [LW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tsc_ram.sv
module tsc_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          core_we,
  input  logic [LW-1:0] core_addr,
  input  logic [DW-1:0] core_din,
  input  logic          ext_we,
  input  logic [LW-1:0] ext_addr,
  input  logic [DW-1:0] ext_din,
  input  logic [LW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [LW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  logic [DW-1:0] mem [DEPTH];

  // the external port wins when both write in the same cycle
  always_ff @(posedge clk) begin
    if (ext_we)       mem[ext_addr]  <= ext_din;
    else if (core_we) mem[core_addr] <= core_din;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/tile_seq_core.sv
module tile_seq_core
  import tsc_pkg::*;
#(
  parameter int DW         = 32,
  parameter int NODE_WORDS = 16,
  parameter int NBR_WORDS  = 4,
  parameter int USER_WORDS = 2048,
  parameter int PROG_WORDS = 16,
  parameter int PRED_BITS  = 8,
  localparam int AW        = $clog2(USER_WORDS),
  localparam int NA        = $clog2(NBR_WORDS),
  localparam int SW        = $clog2(PROG_WORDS),
  localparam int PW        = $clog2(PRED_BITS),
  localparam int P_PEN     = PW,
  localparam int P_DADDR   = PW + 1,
  localparam int P_DSEL    = P_DADDR + AW,
  localparam int P_BADDR   = P_DSEL + SELW,
  localparam int P_BSEL    = P_BADDR + AW,
  localparam int P_AADDR   = P_BSEL + SELW,
  localparam int P_ASEL    = P_AADDR + AW,
  localparam int P_OP      = P_ASEL + SELW,
  localparam int IW        = P_OP + OPW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [SW-1:0]     sched_last,
  input  logic              prog_we,
  input  logic [SW-1:0]     prog_addr,
  input  logic [IW-1:0]     prog_data,
  input  logic              pred_we,
  input  logic [PRED_BITS-1:0] pred_data,
  input  logic [3:0]        nbr_we,
  input  logic [4*NA-1:0]   nbr_addr,
  input  logic [4*DW-1:0]   nbr_data,
  output logic [SW-1:0]     slot,
  output logic              user_tick,
  output logic              tx_valid,
  output logic [DW-1:0]     tx_data,
  output logic              cmp_flag
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  // schedule and instruction fetch
  logic [IW-1:0] ins;

  tsc_seq #(.SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n_int), .run(run), .last(sched_last),
    .slot(slot), .tick(user_tick)
  );

  tsc_prog #(.IW(IW), .DEPTH(PROG_WORDS)) u_prog (
    .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
    .raddr(slot), .rdata(ins)
  );

  alu_op_e         f_op;
  logic [SELW-1:0] f_asel, f_bsel, f_dsel;
  logic [AW-1:0]   f_aaddr, f_baddr, f_daddr;
  logic            f_pen;
  logic [PW-1:0]   f_pidx;

  assign f_op    = alu_op_e'(ins[P_OP +: OPW]);
  assign f_asel  = ins[P_ASEL +: SELW];
  assign f_aaddr = ins[P_AADDR +: AW];
  assign f_bsel  = ins[P_BSEL +: SELW];
  assign f_baddr = ins[P_BADDR +: AW];
  assign f_dsel  = ins[P_DSEL +: SELW];
  assign f_daddr = ins[P_DADDR +: AW];
  assign f_pen   = ins[P_PEN];
  assign f_pidx  = ins[PW-1:0];

  // predicate bits from the bit-level array
  logic [PRED_BITS-1:0] pred_q, pred_d;
  logic                 exec;

  assign exec = run && (!f_pen || pred_q[f_pidx]);

  // operand stores
  logic [DW-1:0] rda [8];
  logic [DW-1:0] rdb [8];
  logic [7:0]    wr_en;
  logic [DW-1:0] alu_y;
  logic          alu_eq;

  always_comb begin
    for (int k = 0; k < 8; k++) wr_en[k] = exec && (f_dsel == SELW'(k));
  end

  for (genvar g = 0; g < 6; g++) begin : g_space
    localparam int DEP = (g < 2) ? NODE_WORDS : NBR_WORDS;
    localparam int LW  = $clog2(DEP);
    logic          ext_we;
    logic [LW-1:0] ext_addr;
    logic [DW-1:0] ext_din;

    if (g >= 2) begin : g_ext
      assign ext_we   = nbr_we[g-2];
      assign ext_addr = nbr_addr[(g-2)*NA +: NA];
      assign ext_din  = nbr_data[(g-2)*DW +: DW];
    end else begin : g_noext
      assign ext_we   = 1'b0;
      assign ext_addr = '0;
      assign ext_din  = '0;
    end

    tsc_ram #(.DW(DW), .DEPTH(DEP)) u_ram (
      .clk(clk),
      .core_we(wr_en[g]), .core_addr(f_daddr[LW-1:0]), .core_din(alu_y),
      .ext_we(ext_we), .ext_addr(ext_addr), .ext_din(ext_din),
      .ra_addr(f_aaddr[LW-1:0]), .ra_data(rda[g]),
      .rb_addr(f_baddr[LW-1:0]), .rb_data(rdb[g])
    );
  end

  tsc_ram #(.DW(DW), .DEPTH(USER_WORDS)) u_user (
    .clk(clk),
    .core_we(wr_en[SP_USER]), .core_addr(f_daddr), .core_din(alu_y),
    .ext_we(1'b0), .ext_addr('0), .ext_din('0),
    .ra_addr(f_aaddr), .ra_data(rda[6]),
    .rb_addr(f_baddr), .rb_data(rdb[6])
  );

  assign rda[7] = '0;
  assign rdb[7] = '0;

  tsc_alu #(.DW(DW)) u_alu (
    .op(f_op), .a(rda[f_asel]), .b(rdb[f_bsel]), .y(alu_y), .eq(alu_eq)
  );

  // outputs: next state
  logic          tx_valid_d, flag_d;
  logic [DW-1:0] tx_data_d;

  always_comb begin
    pred_d     = pred_we ? pred_data : pred_q;
    tx_valid_d = wr_en[SP_PORT];
    tx_data_d  = wr_en[SP_PORT] ? alu_y : tx_data;
    flag_d     = (exec && f_op == OP_CMPEQ) ? alu_eq : cmp_flag;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      pred_q   <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      cmp_flag <= 1'b0;
    end else begin
      pred_q   <= pred_d;
      tx_valid <= tx_valid_d;
      tx_data  <= tx_data_d;
      cmp_flag <= flag_d;
    end
  end
endmodule

// File: rtl/tsc_chk.sv
module tsc_chk #(
  parameter int SW        = 4,
  parameter int PRED_BITS = 8,
  parameter int PW        = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 run,
  input logic [SW-1:0]        sched_last,
  input logic [SW-1:0]        slot,
  input logic                 user_tick,
  input logic                 tx_valid,
  input logic                 cmp_flag,
  input logic [PRED_BITS-1:0] pred_q,
  input logic                 f_pen,
  input logic [PW-1:0]        f_pidx,
  input logic [2:0]           f_dsel
);
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run && slot == sched_last |=> slot == '0); // R2

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(slot) && !tx_valid); // R2

  AST_TICK_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    user_tick |-> $past(run) && $past(slot) == $past(sched_last)); // R2

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    run && f_pen && !pred_q[f_pidx] |=> !tx_valid && $stable(cmp_flag)); // R6

  AST_PORT_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    run && !f_pen && f_dsel == 3'd7 |=> tx_valid); // R9

  AST_TX_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(run)); // R9
endmodule

bind tile_seq_core tsc_chk #(.SW(SW), .PRED_BITS(PRED_BITS), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n_int), .run(run), .sched_last(sched_last),
  .slot(slot), .user_tick(user_tick), .tx_valid(tx_valid),
  .cmp_flag(cmp_flag), .pred_q(pred_q), .f_pen(f_pen), .f_pidx(f_pidx),
  .f_dsel(f_dsel)
);

// File: tb/test_tile_seq_core.sv
`timescale 1ns/1ps
module test_tile_seq_core;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run = 1'b0;
  logic [3:0]   sched_last = '0;
  logic         prog_we = 1'b0;
  logic [3:0]   prog_addr = '0;
  logic [48:0]  prog_data = '0;
  logic         pred_we = 1'b0;
  logic [7:0]   pred_data = '0;
  logic [3:0]   nbr_we = '0;
  logic [7:0]   nbr_addr = '0;
  logic [127:0] nbr_data = '0;
  logic [3:0]   slot;
  logic         user_tick, tx_valid, cmp_flag;
  logic [31:0]  tx_data;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  tile_seq_core i_tile_seq_core (
    .clk(clk), .rst_n(rst_n), .run(run), .sched_last(sched_last),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .pred_we(pred_we), .pred_data(pred_data),
    .nbr_we(nbr_we), .nbr_addr(nbr_addr), .nbr_data(nbr_data),
    .slot(slot), .user_tick(user_tick), .tx_valid(tx_valid),
    .tx_data(tx_data), .cmp_flag(cmp_flag)
  );

  // space codes and opcodes as given in R3 and R4
  localparam logic [2:0] RN = 3'd0, XN = 3'd1, NO = 3'd2, SO = 3'd3, US = 3'd6, ZP = 3'd7;
  localparam logic [2:0] ADD = 3'd0, SUB = 3'd1, AND_ = 3'd2, OR_ = 3'd3, XOR_ = 3'd4,
                         PSA = 3'd5, CEQ = 3'd6, PSB = 3'd7;

  // instruction packing per the R3 field layout
  function automatic logic [48:0] mk(input logic [2:0] op, input logic [2:0] as,
      input logic [10:0] aa, input logic [2:0] bs, input logic [10:0] ba,
      input logic [2:0] ds, input logic [10:0] da, input logic pe, input logic [2:0] pi);
    return {op, as, aa, bs, ba, ds, da, pe, pi};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic nbr_wr(input int d, input int ad, input logic [31:0] v);
    nbr_we = '0;
    nbr_we[d] = 1'b1;
    nbr_addr[d*2 +: 2] = ad[1:0];
    nbr_data[d*32 +: 32] = v;
    step();
    nbr_we = '0;
  endtask

  task automatic prog_wr(input int s, input logic [48:0] w);
    prog_we = 1'b1;
    prog_addr = s[3:0];
    prog_data = w;
    step();
    prog_we = 1'b0;
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // {op, a, b, expected result, expected flag}
  localparam int NV = 11;
  localparam logic [99:0] VEC [NV] = '{
    {ADD,  32'h0000_0005, 32'h0000_0007, 32'h0000_000c, 1'b0},
    {ADD,  32'hffff_ffff, 32'h0000_0001, 32'h0000_0000, 1'b0},
    {SUB,  32'h0000_0003, 32'h0000_0005, 32'hffff_fffe, 1'b0},
    {AND_, 32'hf0f0_f0f0, 32'hff00_ff00, 32'hf000_f000, 1'b0},
    {OR_,  32'h0f00_0000, 32'h0000_00f0, 32'h0f00_00f0, 1'b0},
    {XOR_, 32'haaaa_5555, 32'hffff_0000, 32'h5555_5555, 1'b0},
    {PSA,  32'h1234_5678, 32'h0000_0001, 32'h1234_5678, 1'b0},
    {PSB,  32'h0000_0001, 32'h9abc_def0, 32'h9abc_def0, 1'b0},
    {CEQ,  32'h0000_0077, 32'h0000_0078, 32'h0000_0000, 1'b0},
    {CEQ,  32'h0000_0077, 32'h0000_0077, 32'h0000_0001, 1'b1},
    {ADD,  32'h0000_0001, 32'h0000_0001, 32'h0000_0002, 1'b1}
  };

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_up();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1: reset state
    chk("R1 slot", 32'(slot), 32'd0);
    chk("R1 user_tick", 32'(user_tick), 32'd0);
    chk("R1 tx_valid", 32'(tx_valid), 32'd0);
    chk("R1 cmp_flag", 32'(cmp_flag), 32'd0);

    // R3/R4/R5/R10: vector walk, operands from north[0] and south[0]
    sched_last = 4'd0;
    for (int i = 0; i < NV; i++) begin
      nbr_we = 4'b0011;
      nbr_addr = '0;
      nbr_data[31:0]  = VEC[i][96:65];
      nbr_data[63:32] = VEC[i][64:33];
      prog_we = 1'b1;
      prog_addr = 4'd0;
      prog_data = mk(VEC[i][99:97], NO, 11'd0, SO, 11'd0, ZP, 11'd0, 1'b0, 3'd0);
      step();
      nbr_we = '0;
      prog_we = 1'b0;
      run = 1'b1;
      step();
      run = 1'b0;
      chk("R4 R10 tx_data", tx_data, VEC[i][32:1]);
      chk("R9 tx_valid", 32'(tx_valid), 32'd1);
      chk("R5 cmp_flag", 32'(cmp_flag), 32'(VEC[i][0]));
    end

    // R2: four-slot schedule, wrap, tick and hold
    for (int s = 0; s < 4; s++)
      prog_wr(s, mk(PSA, ZP, 11'd0, ZP, 11'd0, ZP, 11'd0, 1'b0, 3'd0));
    sched_last = 4'd3;
    run = 1'b1;
    step();
    chk("R2 slot advance", 32'(slot), 32'd1);
    chk("R2 no tick mid pass", 32'(user_tick), 32'd0);
    run = 1'b0;
    step();
    chk("R2 hold slot", 32'(slot), 32'd1);
    chk("R2 idle no tx", 32'(tx_valid), 32'd0);
    run = 1'b1;
    step();
    step();
    chk("R2 slot 3", 32'(slot), 32'd3);
    step();
    chk("R2 wrap", 32'(slot), 32'd0);
    chk("R2 tick", 32'(user_tick), 32'd1);
    step();
    chk("R2 tick one cycle", 32'(user_tick), 32'd0);
    step(); step(); step();
    run = 1'b0;

    // R7/R8: wire node R0 and register node X0
    nbr_wr(0, 1, 32'd100);
    prog_wr(0, mk(PSA, NO, 11'd1, ZP, 11'd0, XN, 11'd0, 1'b0, 3'd0));
    sched_last = 4'd0;
    run = 1'b1; step(); run = 1'b0;
    nbr_wr(0, 0, 32'd5);
    prog_wr(0, mk(PSA, NO, 11'd0, ZP, 11'd0, RN, 11'd0, 1'b0, 3'd0));
    prog_wr(1, mk(ADD, RN, 11'd0, XN, 11'd0, ZP, 11'd0, 1'b0, 3'd0));
    prog_wr(2, mk(PSA, RN, 11'd0, ZP, 11'd0, XN, 11'd0, 1'b0, 3'd0));
    sched_last = 4'd2;
    run = 1'b1;
    step();
    chk("R9 no tx after slot 0", 32'(tx_valid), 32'd0);
    step();
    chk("R7 R8 pass 1", tx_data, 32'd105);
    step();
    run = 1'b0;
    nbr_wr(0, 0, 32'd7);
    run = 1'b1;
    step(); step();
    chk("R7 wire sees new value", tx_data, 32'd12);
    step();
    run = 1'b0;
    chk("R8 register pass done", 32'(user_tick), 32'd1);

    // R6: predicate on bit 5
    pred_we = 1'b1; pred_data = 8'h20; step(); pred_we = 1'b0;
    nbr_wr(0, 1, 32'd11);
    prog_wr(0, mk(PSA, NO, 11'd1, ZP, 11'd0, RN, 11'd3, 1'b1, 3'd5));
    prog_wr(1, mk(PSA, RN, 11'd3, ZP, 11'd0, ZP, 11'd0, 1'b0, 3'd0));
    prog_wr(2, mk(CEQ, NO, 11'd1, ZP, 11'd0, ZP, 11'd0, 1'b1, 3'd5));
    run = 1'b1;
    step(); step();
    chk("R6 enabled write", tx_data, 32'd11);
    step();
    chk("R6 enabled compare", 32'(cmp_flag), 32'd0);
    chk("R6 enabled compare tx", 32'(tx_valid), 32'd1);
    run = 1'b0;
    nbr_wr(0, 1, 32'd0);
    pred_we = 1'b1; pred_data = 8'h01; step(); pred_we = 1'b0;
    run = 1'b1;
    step(); step();
    chk("R6 skipped write", tx_data, 32'd11);
    step();
    run = 1'b0;
    chk("R6 skipped tx", 32'(tx_valid), 32'd0);
    chk("R6 skipped flag", 32'(cmp_flag), 32'd0);
    chk("R6 slot still wraps", 32'(user_tick), 32'd1);

    // R11: top and bottom of user memory
    nbr_wr(0, 0, 32'hdead_beef);
    prog_wr(0, mk(PSA, NO, 11'd0, ZP, 11'd0, US, 11'd2047, 1'b0, 3'd0));
    prog_wr(1, mk(PSA, ZP, 11'd0, ZP, 11'd0, US, 11'd0, 1'b0, 3'd0));
    prog_wr(2, mk(PSB, ZP, 11'd0, US, 11'd2047, ZP, 11'd0, 1'b0, 3'd0));
    run = 1'b1;
    step(); step(); step();
    run = 1'b0;
    chk("R11 top word", tx_data, 32'hdead_beef);

    finish_up();
  end
endmodule